// File: doc/BRIEF.md
# Pulse-Triggered Master-Slave JK Flip-Flop Model

This block is a synthesizable, cycle-accurate model of a JK storage element that uses a master stage and a slave stage. A fast, free-running system clock samples a slow control line, which is handled as ordinary data, along with the J and K inputs. The master stage can change only while the control line is high. The slave stage, which drives the visible output, takes the master's value when the control line returns low. The output change is therefore held back until the end of each control pulse.

The model reproduces the "catching" behaviour of this kind of flip-flop. Consider a brief J or K level that appears at any time in the high window, when the slave's current state allows that input to act. It is captured into the master and cannot be undone later in the same window. The output then follows at the falling edge of the control line, and a one-cycle flag reports that the captured value came from an input that had already gone away. All three inputs pass through multi-stage synchronizers before use, so the block can watch a control line that is asynchronous to the system clock. A synchronous reset clears all state.

Top module: `pulse_jk_ff`

## Requirements
- R1: While `rst` is high at a rising system-clock edge, the block clears master, slave and flag state. After that edge, `q`=0, `q_n`=1 and `catch_flag`=0, whatever the other inputs are.
- R2: `q_n` is always the complement of `q`.
- R3: `q` changes only on the clock edge that follows the cycle in which the synchronized control line is seen going from 1 to 0.
- R4: While the synchronized control line is 0, J and K have no effect. Neither `q` nor the value that the next falling edge transfers is changed.
- R5: If J=1 and K=0 are held for a whole control pulse, `q` is 1 after the pulse.
- R6: If J=0 and K=1 are held for a whole control pulse, `q` is 0 after the pulse.
- R7: If J=1 and K=1 are held for a whole control pulse, `q` is inverted after the pulse.
- R8: If J=0 and K=0 are held for a whole control pulse, `q` keeps its value.
- R9: Ones catching. With `q`=0, a J pulse of at least one cycle at any point in the high window makes `q`=1 after the falling edge, even if J is back to 0 by then.
- R10: Zeros catching. With `q`=1, a K pulse in the high window makes `q`=0 after the falling edge. A J pulse that comes later in the same window does not set it back.
- R11: `catch_flag` is high for exactly one cycle, in the cycle `q` takes its new value, only when the master differs from the slave at the falling edge and the input responsible for that change (J when `q` was 0, K when `q` was 1) reads 0 at that edge.
- R12: Each input passes through SYNC_STAGES (default 2) synchronizer flops. With the default, `q` takes its new value on the 3rd rising clock edge after the control input falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_in | input | 1 | Slow control pulse line (asynchronous data) |
| j_in | input | 1 | J information input |
| k_in | input | 1 | K information input |
| q | output | 1 | Slave state |
| q_n | output | 1 | Complement of the slave state |
| catch_flag | output | 1 | One-cycle flag for a captured input that had already gone away |

## Verification
The hardest situations to reach are the two catching cases. In each, the master has to be set or cleared by a J or K pulse that lasts a single system clock cycle inside a long high window. The pulse must then be gone before the falling edge, and in the zeros case a later opposing pulse must also be ignored. The stimulus reaches these cases by raising the control line first, then placing one-cycle pulses at chosen offsets inside the window, then holding the line high for several more cycles so that every pulse has cleared the synchronizer before the line drops. A reference model that tracks the synchronizer delay is compared with the outputs on every clock, and directed checks sample `q` and the flag exactly two and three edges after the control line falls.

// File: rtl/mjk_pkg.sv
package mjk_pkg;

    // Synchronized view of the three information/control lines.
    typedef struct packed {
        logic c;
        logic j;
        logic k;
    } ctl_t;

    localparam int unsigned CTL_W = $bits(ctl_t);

    // Two storage bits of the emulated element.
    typedef struct packed {
        logic master;
        logic slave;
    } ms_state_t;

    // Master update while the control line is high. The slave output gates
    // which input may act: only J from the 0 state, only K from the 1 state.
    function automatic logic master_next(ms_state_t s, logic j, logic k);
        logic nxt;
        nxt = s.master;
        if (!s.slave && j)
            nxt = 1'b1;
        else if (s.slave && k)
            nxt = 1'b0;
        return nxt;
    endfunction

    // A captured change whose responsible input is already low at the edge.
    function automatic logic catch_hit(ms_state_t s, logic j, logic k);
        logic cause;
        cause = s.slave ? k : j;
        return (s.master != s.slave) && !cause;
    endfunction

endpackage

// File: rtl/mjk_sync.sv
module mjk_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++)
                chain[i] <= chain[i-1];
        end
    end

    assign q = chain[LAST];
endmodule

// File: rtl/mjk_fall_det.sv
module mjk_fall_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic fall
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    assign fall = prev & ~lvl;
endmodule

// File: rtl/mjk_core.sv
module mjk_core
    import mjk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t in_s,
    input  logic fall,
    output logic slave_o,
    output logic master_o,
    output logic catch_o
);
    ms_state_t st;
    logic      flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            flag <= 1'b0;
        end else begin
            flag <= 1'b0;
            if (fall) begin
                st.slave <= st.master;
                flag     <= catch_hit(st, in_s.j, in_s.k);
            end else if (in_s.c) begin
                st.master <= master_next(st, in_s.j, in_s.k);
            end
        end
    end

    assign slave_o  = st.slave;
    assign master_o = st.master;
    assign catch_o  = flag;
endmodule

// File: rtl/pulse_jk_ff.sv
module pulse_jk_ff
    import mjk_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ctl_in,
    input  logic j_in,
    input  logic k_in,
    output logic q,
    output logic q_n,
    output logic catch_flag
);
    ctl_t raw_in;
    ctl_t sync_s;
    logic fall;
    logic master_bit;
    logic slave_bit;

    assign raw_in = '{c: ctl_in, j: j_in, k: k_in};

    mjk_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_s)
    );

    mjk_fall_det u_fall (
        .clk  (clk),
        .rst  (rst),
        .lvl  (sync_s.c),
        .fall (fall)
    );

    mjk_core u_core (
        .clk      (clk),
        .rst      (rst),
        .in_s     (sync_s),
        .fall     (fall),
        .slave_o  (slave_bit),
        .master_o (master_bit),
        .catch_o  (catch_flag)
    );

    assign q   = slave_bit;
    assign q_n = ~slave_bit;
endmodule

// File: rtl/mjk_checker.sv
module mjk_checker (
    input logic clk,
    input logic rst,
    input logic q,
    input logic catch_flag,
    input logic c_sync,
    input logic fall,
    input logic master
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!q && !catch_flag)); // R1

    AST_Q_ONLY_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        !fall |=> $stable(q)); // R3

    AST_MASTER_FROZEN_LOW: assert property (@(posedge clk) disable iff (rst)
        !c_sync |=> $stable(master)); // R4

    AST_FLAG_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        catch_flag |=> !catch_flag); // R11

    AST_FLAG_WITH_CHANGE: assert property (@(posedge clk) disable iff (rst)
        catch_flag |-> (q != $past(q))); // R11
endmodule

bind pulse_jk_ff mjk_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .q          (q),
    .catch_flag (catch_flag),
    .c_sync     (sync_s.c),
    .fall       (fall),
    .master     (master_bit)
);

// File: tb/test_pulse_jk_ff.sv
module test_pulse_jk_ff;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_in = 1'b0;
    logic j_in = 1'b0;
    logic k_in = 1'b0;
    logic q, q_n, catch_flag;

    int checks = 0;
    int failures = 0;
    bit started = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pulse_jk_ff #(.SYNC_STAGES(SYNC)) i_pulse_jk_ff (
        .clk(clk), .rst(rst), .ctl_in(ctl_in), .j_in(j_in), .k_in(k_in),
        .q(q), .q_n(q_n), .catch_flag(catch_flag)
    );

    // Behavioural reference: delay lines for the inputs, then the rules.
    bit cq[$], jq[$], kq[$];
    bit m_master, m_q, m_flag, m_cprev;

    always @(posedge clk) begin
        bit cc, cj, ck, fell;
        started = 1;
        if (rst) begin
            cq.delete(); jq.delete(); kq.delete();
            for (int i = 0; i < SYNC; i++) begin
                cq.push_back(0); jq.push_back(0); kq.push_back(0);
            end
            m_master = 0; m_q = 0; m_flag = 0; m_cprev = 0;
        end else begin
            cc = cq.pop_front(); cj = jq.pop_front(); ck = kq.pop_front();
            cq.push_back(ctl_in); jq.push_back(j_in); kq.push_back(k_in);
            fell = m_cprev && !cc;
            m_cprev = cc;
            m_flag = 0;
            if (fell) begin
                if (m_master != m_q)
                    m_flag = (m_q == 0) ? !cj : !ck;
                m_q = m_master;
            end else if (cc) begin
                if (m_q == 0 && cj == 1) m_master = 1;
                if (m_q == 1 && ck == 1) m_master = 0;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the reference model.
    always @(negedge clk) begin
        if (started && !finished) begin
            check(q === m_q, "R3 q vs model", q, m_q);
            check(q_n === ~q, "R2 q_n complement", q_n, ~q);
            check(catch_flag === m_flag, "R11 flag vs model", catch_flag, m_flag);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Full pulse with J/K held from before the rise to after the fall.
    task automatic pulse(input bit jv, input bit kv);
        j_in = jv; k_in = kv;
        cyc(4);
        ctl_in = 1'b1;
        cyc(6);
        ctl_in = 1'b0;
        cyc(6);
        j_in = 0; k_in = 0;
        cyc(2);
    endtask

    task automatic report;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        // R1: reset dominates active inputs
        ctl_in = 1; j_in = 1; k_in = 1;
        cyc(6);
        check(q == 0 && q_n == 1 && catch_flag == 0, "R1 reset state", q, 0);
        ctl_in = 0; j_in = 0; k_in = 0;
        cyc(3);
        rst = 0;
        cyc(3);

        pulse(0, 0);
        check(q == 0, "R8 hold at 0", q, 0);
        pulse(1, 0);
        check(q == 1, "R5 set", q, 1);
        pulse(0, 0);
        check(q == 1, "R8 hold at 1", q, 1);
        pulse(1, 1);
        check(q == 0, "R7 toggle 1->0", q, 0);
        pulse(1, 1);
        check(q == 1, "R7 toggle 0->1", q, 1);
        pulse(0, 1);
        check(q == 0, "R6 reset", q, 0);

        // R4: J activity with control low is ignored now and later
        j_in = 1; cyc(10);
        check(q == 0, "R4 J while low", q, 0);
        j_in = 0; cyc(3);
        pulse(0, 0);
        check(q == 0, "R4 master unchanged", q, 0);

        // R12: latency from control fall to output
        j_in = 1; cyc(4);
        ctl_in = 1; cyc(8);
        ctl_in = 0;
        cyc(2);
        check(q == 0, "R12 not yet after 2 edges", q, 0);
        cyc(1);
        check(q == 1, "R12 updated on 3rd edge", q, 1);
        check(catch_flag == 0, "R11 no flag with J held", catch_flag, 0);
        j_in = 0; cyc(4);
        pulse(0, 1);
        check(q == 0, "R6 reset again", q, 0);

        // R9: ones catching
        ctl_in = 1; cyc(2);
        j_in = 1; cyc(1); j_in = 0;
        cyc(2);
        k_in = 1; cyc(1); k_in = 0;
        cyc(4);
        ctl_in = 0;
        cyc(2);
        check(q == 0, "R9 deferred to fall", q, 0);
        cyc(1);
        check(q == 1, "R9 ones caught", q, 1);
        check(catch_flag == 1, "R11 flag on ones catch", catch_flag, 1);
        cyc(1);
        check(catch_flag == 0, "R11 flag one cycle", catch_flag, 0);
        cyc(4);

        // R10: zeros catching, later J does not set again
        ctl_in = 1; cyc(2);
        k_in = 1; cyc(1); k_in = 0;
        cyc(3);
        j_in = 1; cyc(2); j_in = 0;
        cyc(4);
        ctl_in = 0;
        cyc(3);
        check(q == 0, "R10 zeros caught", q, 0);
        check(catch_flag == 1, "R11 flag on zeros catch", catch_flag, 1);
        cyc(1);
        check(catch_flag == 0, "R11 flag cleared", catch_flag, 0);
        cyc(4);

        // R1: reset mid-operation from q=1
        pulse(1, 0);
        check(q == 1, "R5 set before reset", q, 1);
        rst = 1; cyc(2);
        check(q == 0 && q_n == 1, "R1 reset clears q", q, 0);
        rst = 0; cyc(4);

        report();
    end
endmodule